// File: doc/BRIEF.md
# Two-Half Programmable Periodic Interrupt Timer

This block is a 24-bit down-counter that raises a periodic interrupt from a slow tick enable, nominally one pulse per period of a 32.768 kHz reference (about 30 µs). Software programs the period through a 16-bit register bus. The period is split into a low half and a high half, and each half is written by its own strobe. A new period becomes active only after both halves have been written since the last commit. A write to only one half changes what that half reads back, but the counter keeps running on the old period.

With a committed period m, the counter loads m on the first tick after the commit. After that it steps down by one per tick. On the tick where it holds 1, it emits a one-clock interrupt pulse and reloads m. Interrupts are therefore spaced exactly m ticks apart. A period of zero parks the counter and silences the interrupt. Software is expected to program 4 or more, and the hardware does not clamp smaller values. Only the dedicated asynchronous timer reset initialises the registers.

Top module: `long_period_timer`

## Requirements
- R1: While and after the timer reset (active low), both readback ports show 0, the active period is 0, and no interrupt pulse occurs until a non-zero period is committed.
- R2: A low-half write strobe stores all 16 data bits. They read back on `periodLoRd` from the next clock, whether or not the pair has been committed.
- R3: A high-half write stores data bits 7..0 as period bits 23..16. Bits 15..8 of `periodHiRd` always read 0, whatever was written. The stored high bits take part in the committed period.
- R4: Writing only one half leaves the active period and the interrupt spacing unchanged.
- R5: Once both halves have been written, in either order and on separate cycles, the pair `{high[7:0], low[15:0]}` is committed one clock later and both write flags clear. A further single-half write does not commit again.
- R6: The first tick after a commit loads the new period and produces no interrupt. This happens even if the old count was mid-period.
- R7: With period m ≥ 2, the interrupt follows the m-th, 2m-th, 3m-th … tick after the load tick, and follows no other tick.
- R8: The interrupt is one clock wide. It appears in the clock after the tick enable that caused it and never without such a tick.
- R9: A committed period of 0 halts the counter, and no interrupt is produced until a non-zero period is committed.
- R10: Clock cycles without a tick enable do not change the count, so idle gaps of any length do not shift the interrupt schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| timerRstN | input | 1 | Asynchronous timer reset, active low |
| tickEn | input | 1 | One-clock count enable at the slow tick rate |
| wrLo | input | 1 | Write strobe for the low period half |
| wrHi | input | 1 | Write strobe for the high period half |
| wrData | input | 16 | Write data for either half |
| irqPulse | output | 1 | Periodic interrupt pulse, one clock wide |
| periodLoRd | output | 16 | Readback of the low period half |
| periodHiRd | output | 16 | Readback of the high period half, upper byte zero |

## Verification
A corrupted count or a missed reload shows at `irqPulse` within one period of ticks: the next interrupt arrives on the wrong tick, is missing, or appears twice. A write flag stuck set or stuck clear shows as a commit that happens too early or not at all. The bench sees this on the first period change after the fault, as interrupt spacing that does not match the value the bench predicts. A wrong shadow register shows at the readback ports in the clock after the write.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  // Strobes that the control issues to the datapath each clock.
  typedef struct packed {
    logic latchLo;    // capture wrData into the low shadow
    logic latchHi;    // capture wrData into the high shadow
    logic commit;     // move both shadows into the active period
    logic reload;     // load the active period into the counter
    logic decrement;  // count down by one
    logic fireIrq;    // emit the interrupt pulse at the next edge
  } lptStrobes_t;

endpackage

// File: rtl/lpt_control.sv
module lpt_control
  import lpt_pkg::*;
(
  input  logic        clk,
  input  logic        timerRstN,
  input  logic        tickEn,
  input  logic        wrLo,
  input  logic        wrHi,
  input  logic        countIsOne,
  input  logic        countIsZero,
  input  logic        periodIsZero,
  output lptStrobes_t ctrlStr
);

  logic loFlag;
  logic hiFlag;
  logic restartPending;
  logic pairReady;

  assign pairReady = loFlag & hiFlag;

  // Write flags: each set by its own strobe, both cleared by a commit.
  always_ff @(posedge clk or negedge timerRstN) begin
    if (!timerRstN) begin
      loFlag <= 1'b0;
      hiFlag <= 1'b0;
    end else begin
      if (wrLo)           loFlag <= 1'b1;
      else if (pairReady) loFlag <= 1'b0;
      if (wrHi)           hiFlag <= 1'b1;
      else if (pairReady) hiFlag <= 1'b0;
    end
  end

  // A commit forces a fresh load on the following tick.
  always_ff @(posedge clk or negedge timerRstN) begin
    if (!timerRstN) begin
      restartPending <= 1'b0;
    end else if (pairReady) begin
      restartPending <= 1'b1;
    end else if (tickEn) begin
      restartPending <= 1'b0;
    end
  end

  always_comb begin
    ctrlStr           = '0;
    ctrlStr.latchLo   = wrLo;
    ctrlStr.latchHi   = wrHi;
    ctrlStr.commit    = pairReady;
    ctrlStr.reload    = tickEn & (restartPending | countIsOne | countIsZero);
    ctrlStr.decrement = tickEn & ~(restartPending | countIsOne | countIsZero);
    ctrlStr.fireIrq   = tickEn & ~restartPending & countIsOne & ~periodIsZero;
  end

endmodule

// File: rtl/lpt_datapath.sv
module lpt_datapath
  import lpt_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             timerRstN,
  input  lptStrobes_t      ctrlStr,
  input  logic [BUS_W-1:0] wrData,
  output logic             countIsOne,
  output logic             countIsZero,
  output logic             periodIsZero,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] activePeriod,
  output logic             irqPulse,
  output logic [BUS_W-1:0] periodLoRd,
  output logic [BUS_W-1:0] periodHiRd
);

  localparam int HI_W = CNT_W - BUS_W;

  logic [BUS_W-1:0] loShadow;
  logic [HI_W-1:0]  hiShadow;
  logic [CNT_W-1:0] count;
  logic             irqReg;

  // Shadow halves, visible at readback before any commit.
  always_ff @(posedge clk or negedge timerRstN) begin
    if (!timerRstN) begin
      loShadow <= '0;
      hiShadow <= '0;
    end else begin
      if (ctrlStr.latchLo) loShadow <= wrData;
      if (ctrlStr.latchHi) hiShadow <= wrData[HI_W-1:0];
    end
  end

  // Active period, changed only by a commit.
  always_ff @(posedge clk or negedge timerRstN) begin
    if (!timerRstN) begin
      activePeriod <= '0;
    end else if (ctrlStr.commit) begin
      activePeriod <= {hiShadow, loShadow};
    end
  end

  // Down-counter.
  always_ff @(posedge clk or negedge timerRstN) begin
    if (!timerRstN) begin
      count <= '0;
    end else if (ctrlStr.reload) begin
      count <= activePeriod;
    end else if (ctrlStr.decrement) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge timerRstN) begin
    if (!timerRstN) irqReg <= 1'b0;
    else            irqReg <= ctrlStr.fireIrq;
  end

  assign countIsOne   = (count == CNT_W'(1));
  assign countIsZero  = (count == '0);
  assign periodIsZero = (activePeriod == '0);
  assign countVal     = count;
  assign irqPulse     = irqReg;
  assign periodLoRd   = loShadow;

  generate
    if (HI_W < BUS_W) begin : g_hiPad
      assign periodHiRd = {{(BUS_W-HI_W){1'b0}}, hiShadow};
    end else begin : g_hiFull
      assign periodHiRd = hiShadow[BUS_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/long_period_timer.sv
module long_period_timer
  import lpt_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             timerRstN,
  input  logic             tickEn,
  input  logic             wrLo,
  input  logic             wrHi,
  input  logic [BUS_W-1:0] wrData,
  output logic             irqPulse,
  output logic [BUS_W-1:0] periodLoRd,
  output logic [BUS_W-1:0] periodHiRd
);

  lptStrobes_t      ctrlStr;
  logic             countIsOne;
  logic             countIsZero;
  logic             periodIsZero;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] activePeriod;

  lpt_control u_ctrl (
    .clk          (clk),
    .timerRstN    (timerRstN),
    .tickEn       (tickEn),
    .wrLo         (wrLo),
    .wrHi         (wrHi),
    .countIsOne   (countIsOne),
    .countIsZero  (countIsZero),
    .periodIsZero (periodIsZero),
    .ctrlStr      (ctrlStr)
  );

  lpt_datapath #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_dp (
    .clk          (clk),
    .timerRstN    (timerRstN),
    .ctrlStr      (ctrlStr),
    .wrData       (wrData),
    .countIsOne   (countIsOne),
    .countIsZero  (countIsZero),
    .periodIsZero (periodIsZero),
    .countVal     (countVal),
    .activePeriod (activePeriod),
    .irqPulse     (irqPulse),
    .periodLoRd   (periodLoRd),
    .periodHiRd   (periodHiRd)
  );

endmodule

// File: rtl/lpt_checker.sv
module lpt_checker #(
  parameter int CNT_W = 24,
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             timerRstN,
  input logic             tickEn,
  input logic             irqPulse,
  input logic [BUS_W-1:0] periodHiRd,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] activePeriod,
  input logic             commitStr
);

  localparam int HI_W = CNT_W - BUS_W;

  assert_irq_needs_tick_R8: assert property (@(posedge clk) disable iff (!timerRstN)
    irqPulse |-> $past(tickEn));

  assert_zero_period_silent_R9: assert property (@(posedge clk) disable iff (!timerRstN)
    (activePeriod == '0) |=> !irqPulse);

  assert_period_needs_commit_R4: assert property (@(posedge clk) disable iff (!timerRstN)
    !commitStr |=> $stable(activePeriod));

  assert_idle_holds_count_R10: assert property (@(posedge clk) disable iff (!timerRstN)
    !tickEn |=> $stable(countVal));

  assert_hi_upper_zero_R3: assert property (@(posedge clk) disable iff (!timerRstN)
    (periodHiRd >> HI_W) == '0);

endmodule

bind long_period_timer lpt_checker #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
  .clk          (clk),
  .timerRstN    (timerRstN),
  .tickEn       (tickEn),
  .irqPulse     (irqPulse),
  .periodHiRd   (periodHiRd),
  .countVal     (countVal),
  .activePeriod (activePeriod),
  .commitStr    (ctrlStr.commit)
);

// File: tb/long_period_timer_test.sv
`timescale 1ns/1ps
module long_period_timer_test;

  logic        clk = 1'b0;
  logic        timerRstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrLo = 1'b0;
  logic        wrHi = 1'b0;
  logic [15:0] wrData = '0;
  logic        irqPulse;
  logic [15:0] periodLoRd;
  logic [15:0] periodHiRd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int kNow   = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  long_period_timer uut (
    .clk(clk), .timerRstN(timerRstN), .tickEn(tickEn), .wrLo(wrLo), .wrHi(wrHi),
    .wrData(wrData), .irqPulse(irqPulse), .periodLoRd(periodLoRd), .periodHiRd(periodHiRd)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h, expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeLo(input logic [15:0] d);
    @(negedge clk); wrLo = 1'b1; wrData = d;
    @(negedge clk); wrLo = 1'b0;
  endtask

  task automatic writeHi(input logic [15:0] d);
    @(negedge clk); wrHi = 1'b1; wrData = d;
    @(negedge clk); wrHi = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic doTick(input logic expIrq, input string tag);
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    check(tag, irqPulse, expIrq);
    @(negedge clk);
    check("R8 pulse width", irqPulse, 1'b0);
  endtask

  // Load tick after a commit: no interrupt, schedule restarts (R6).
  task automatic loadTick();
    doTick(1'b0, "R6 load tick");
    kNow = 0;
  endtask

  task automatic runTicks(input int m, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      kNow++;
      doTick((m != 0) && (kNow % m == 0), tag);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 lo reset", periodLoRd, 16'h0);
    check("R1 hi reset", periodHiRd, 16'h0);
    check("R1 irq reset", irqPulse, 1'b0);
    timerRstN = 1'b1;
    for (int i = 0; i < 10; i++) doTick(1'b0, "R1 idle after reset");

    // Sweep periods 2..12, low first.
    for (int m = 2; m <= 12; m++) begin
      writeLo(16'(m));
      check("R2 lo readback", periodLoRd, 16'(m));
      writeHi(16'h0);
      settle();
      loadTick();
      runTicks(m, 3 * m, "R7 periodic spacing");
    end

    // High half first, then low (R5).
    writeHi(16'h0);
    writeLo(16'd6);
    settle();
    loadTick();
    runTicks(6, 18, "R5 hi-then-lo commit");

    // Single low write does not change period (R4).
    writeLo(16'd9);
    check("R2 lo readback before commit", periodLoRd, 16'd9);
    runTicks(6, 12, "R4 single write ignored");
    writeHi(16'h0);
    settle();
    loadTick();
    runTicks(9, 18, "R5 commit to 9");
    writeHi(16'h0);
    settle();
    runTicks(9, 9, "R5 flags cleared, no recommit");

    // Idle gap mid-period (R10).
    runTicks(9, 4, "R10 before gap");
    repeat (40) @(negedge clk);
    runTicks(9, 14, "R10 after gap");

    // Mid-period commit restarts the count (R6).
    runTicks(9, 3, "R6 pre-restart");
    writeLo(16'd5);
    writeHi(16'h0);
    settle();
    loadTick();
    runTicks(5, 15, "R6 restart spacing");

    // High byte masking and participation (R3).
    writeHi(16'hFF01);
    check("R3 hi readback masked", periodHiRd, 16'h0001);
    writeLo(16'd5);
    settle();
    loadTick();
    runTicks(32'h10005, 30, "R3 high bits in period");

    // Zero period halts (R9).
    writeLo(16'h0);
    writeHi(16'h0);
    settle();
    loadTick();
    for (int i = 0; i < 20; i++) doTick(1'b0, "R9 zero period silent");
    writeLo(16'd4);
    writeHi(16'h0);
    settle();
    loadTick();
    runTicks(4, 12, "R9 resume after zero");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule